// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer. Its write port and its read port run on unrelated clocks. Each port has its own threshold flag, and both flags are active low. The near-empty flag is registered on the read clock. The near-full flag is registered on the write clock. Each side learns the other side's position from a Gray-coded pointer that passes through a two-stage synchronizer. Because of that delay, the counts each side computes are pessimistic, and a flag may release one cycle late. Full and empty status are given along with the flags.

A three-bit configuration input picks the read mode, and so do the two threshold offsets. These inputs are captured while reset is held and up to the first clock edge after release. In standard mode, a read request returns the head word on the following cycle. In fall-through mode, the head word is moved into an output register by itself. This raises the total capacity by one word and moves the near-empty threshold up by one. Configuration codes that are not defined leave the buffer in standard mode with both flags held inactive.

Top module: `dual_clk_prog_fifo`

## Requirements
- R1: Every word accepted at the write port leaves the read port exactly once, unchanged, and in arrival order, under any interleaving of the two clocks.
- R2: In standard mode, when a read enable is sampled while empty_o is low, rdata_o carries the head word one read-clock cycle later, and valid_o is high in that cycle.
- R3: Capacity D is 256 words in standard mode and 257 in fall-through mode. full_o is high once D words are held, and a write enable sampled while full_o is high changes neither the contents nor the count.
- R4: empty_o is high when no word can be read. A read enable sampled while empty_o is high changes neither the contents nor the count.
- R5: In fall-through mode the head word appears on rdata_o with valid_o high without any read request. valid_o goes low after the last held word is consumed, and empty_o is the inverse of valid_o.
- R6: In standard mode, once status has settled, pae_no is low while at most n words are held and high at n+1 words or more, where n is the near-empty offset.
- R7: In fall-through mode the near-empty threshold is one word higher. Once settled, pae_no is low at n+1 words or fewer and high at n+2 words or more.
- R8: Once settled, paf_no is low while D-m or more words are held and high at D-m-1 words or fewer, where m is the near-full offset.
- R9: While rst_ni is low: empty_o is high, full_o is low, valid_o is low, pae_no is low, and paf_no is high.
- R10: cfg_i codes 3'b100 and 3'b110 select standard mode, and 3'b101 selects fall-through mode. Any other code gives standard mode with pae_no and paf_no held high after reset.
- R11: If ofs_load_i is high during reset, ae_ofs_i sets n and af_ofs_i sets m. Otherwise both offsets default to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both sides |
| cfg_i | input | 3 | Mode and flag-enable code, captured during reset |
| ofs_load_i | input | 1 | Use the offset inputs instead of the defaults, captured during reset |
| ae_ofs_i | input | 9 | Near-empty offset n |
| af_ofs_i | input | 9 | Near-full offset m |
| wr_en_i | input | 1 | Write request |
| wdata_i | input | 18 | Write data |
| full_o | output | 1 | Buffer holds D words |
| paf_no | output | 1 | Near-full flag, active low, write-clock registered |
| rd_en_i | input | 1 | Read request |
| rdata_o | output | 18 | Read data |
| valid_o | output | 1 | rdata_o holds a live word |
| empty_o | output | 1 | Nothing readable |
| pae_no | output | 1 | Near-empty flag, active low, read-clock registered |

## Verification
The hardest state to reach is the fall-through buffer at exactly 257 words. It needs the output register loaded and the RAM completely full, with the write side's view of the read pointer already up to date. The stimulus gets there by writing one word and waiting for it to fall through before filling the rest. The bench checks both flag edges on the way up, and then drives more writes against the full buffer. Threshold edges are checked only after both clocks have idled long enough for the synchronizers to settle. A separate streaming phase has the two clocks run at a ratio other than one-to-one, with write gaps, while every word is compared against a queue.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef struct packed {
    logic fwft;
    logic flags_on;
  } dcf_mode_t;

  function automatic dcf_mode_t dcf_decode(input logic [2:0] sel);
    dcf_mode_t m;
    m.fwft     = (sel == 3'b101);
    m.flags_on = (sel == 3'b100) || (sel == 3'b101) || (sel == 3'b110);
    return m;
  endfunction

endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int PW     = 9,
  parameter int STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] gray_i,
  output logic [PW-1:0] bin_o
);
  logic [PW-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= gray_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  // gray to binary: each bit is the xor of all gray bits at or above it
  always_comb begin
    logic [PW-1:0] b;
    b[PW-1] = stg_q[STAGES-1][PW-1];
    for (int i = PW-2; i >= 0; i--) b[i] = b[i+1] ^ stg_q[STAGES-1][i];
    bin_o = b;
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side import dcf_pkg::*; #(
  parameter int AW     = 8,
  parameter int AF_DEF = 8,
  localparam int PW    = AW + 1,
  localparam int OW    = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cfg_i,
  input  logic          ofs_load_i,
  input  logic [OW-1:0] af_ofs_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] cons_gray_i,
  input  logic [PW-1:0] rrd_gray_i,
  output logic [PW-1:0] wgray_o,
  output logic [AW-1:0] waddr_o,
  output logic          we_o,
  output logic          full_o,
  output logic          paf_no
);
  localparam int RAM_D = 1 << AW;

  logic          in_rst_q;
  dcf_mode_t     cfg_q;
  logic [OW-1:0] af_ofs_q;
  logic [PW-1:0] wbin_q, wbin_nxt, cons_bin, rrd_bin, cnt_tot, cnt_ram;
  logic [PW:0]   depth_w, af_lim;
  logic          paf_n_q;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) in_rst_q <= 1'b1;
    else         in_rst_q <= 1'b0;
  end

  // configuration captured during reset and the first edge after it
  always_ff @(posedge wclk_i) begin
    if (in_rst_q) begin
      cfg_q    <= dcf_decode(cfg_i);
      af_ofs_q <= ofs_load_i ? af_ofs_i : OW'(AF_DEF);
    end
  end

  dcf_gray_sync #(.PW(PW), .STAGES(2)) u_cons_sync (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(cons_gray_i), .bin_o(cons_bin)
  );
  dcf_gray_sync #(.PW(PW), .STAGES(2)) u_rrd_sync (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rrd_gray_i), .bin_o(rrd_bin)
  );

  assign cnt_tot = wbin_q - cons_bin;
  assign cnt_ram = wbin_q - rrd_bin;
  assign depth_w = (PW+1)'(RAM_D) + (PW+1)'(cfg_q.fwft);
  assign af_lim  = ({1'b0, af_ofs_q} >= depth_w) ? '0 : depth_w - {1'b0, af_ofs_q};

  // total count guards capacity; RAM count guards the array in fall-through
  assign full_o   = ({1'b0, cnt_tot} >= depth_w) || (cnt_ram >= PW'(RAM_D));
  assign we_o     = wr_en_i && !full_o;
  assign wbin_nxt = wbin_q + PW'(1);
  assign waddr_o  = wbin_q[AW-1:0];

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_o <= '0;
      paf_n_q <= 1'b1;
    end else begin
      if (we_o) begin
        wbin_q  <= wbin_nxt;
        wgray_o <= wbin_nxt ^ (wbin_nxt >> 1);
      end
      paf_n_q <= cfg_q.flags_on ? !({1'b0, cnt_tot} >= af_lim) : 1'b1;
    end
  end

  assign paf_no = paf_n_q;

  p_cnt_bound_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    {1'b0, cnt_tot} <= depth_w);

  p_full_hold_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> (wbin_q == $past(wbin_q)));

  p_paf_at_full_r8: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (cfg_q.flags_on && $past({1'b0, cnt_tot} >= depth_w)) |-> !paf_no);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side import dcf_pkg::*; #(
  parameter int DW     = 18,
  parameter int AW     = 8,
  parameter int AE_DEF = 8,
  localparam int PW    = AW + 1,
  localparam int OW    = AW + 1
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cfg_i,
  input  logic          ofs_load_i,
  input  logic [OW-1:0] ae_ofs_i,
  input  logic          rd_en_i,
  input  logic [PW-1:0] wgray_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] cons_gray_o,
  output logic [PW-1:0] rrd_gray_o,
  output logic [DW-1:0] rdata_o,
  output logic          valid_o,
  output logic          empty_o,
  output logic          pae_no
);
  localparam int RAM_D = 1 << AW;

  logic          in_rst_q;
  dcf_mode_t     cfg_q;
  logic [OW-1:0] ae_ofs_q;
  logic [PW-1:0] wbin_s, rrd_q, cons_q, rrd_nxt, cons_nxt, ram_cnt, tot;
  logic [OW:0]   ae_thr;
  logic          ram_avail, take, consume, out_v_q, pae_n_q;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) in_rst_q <= 1'b1;
    else         in_rst_q <= 1'b0;
  end

  always_ff @(posedge rclk_i) begin
    if (in_rst_q) begin
      cfg_q    <= dcf_decode(cfg_i);
      ae_ofs_q <= ofs_load_i ? ae_ofs_i : OW'(AE_DEF);
    end
  end

  dcf_gray_sync #(.PW(PW), .STAGES(2)) u_w_sync (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wgray_i), .bin_o(wbin_s)
  );

  assign ram_cnt   = wbin_s - rrd_q;
  assign tot       = wbin_s - cons_q;
  assign ram_avail = (ram_cnt != '0);
  assign ae_thr    = {1'b0, ae_ofs_q} + (OW+1)'(cfg_q.fwft);

  // take: RAM word moves to output register; consume: user read retires a word
  always_comb begin
    if (cfg_q.fwft) begin
      take    = ram_avail && (!out_v_q || rd_en_i);
      consume = rd_en_i && out_v_q;
    end else begin
      take    = rd_en_i && ram_avail;
      consume = take;
    end
  end

  assign rrd_nxt  = rrd_q + PW'(1);
  assign cons_nxt = cons_q + PW'(1);
  assign raddr_o  = rrd_q[AW-1:0];

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rrd_q       <= '0;
      cons_q      <= '0;
      rrd_gray_o  <= '0;
      cons_gray_o <= '0;
      out_v_q     <= 1'b0;
      pae_n_q     <= 1'b0;
    end else begin
      if (take) begin
        rrd_q      <= rrd_nxt;
        rrd_gray_o <= rrd_nxt ^ (rrd_nxt >> 1);
      end
      if (consume) begin
        cons_q      <= cons_nxt;
        cons_gray_o <= cons_nxt ^ (cons_nxt >> 1);
      end
      if (cfg_q.fwft) out_v_q <= take | (out_v_q & ~consume);
      else            out_v_q <= take;
      pae_n_q <= cfg_q.flags_on ? !({1'b0, tot} <= ae_thr) : 1'b1;
    end
  end

  always_ff @(posedge rclk_i) begin
    if (take) rdata_o <= mem_rdata_i;
  end

  assign valid_o = out_v_q;
  assign empty_o = cfg_q.fwft ? !out_v_q : !ram_avail;
  assign pae_no  = pae_n_q;

  p_cnt_bound_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (tot <= PW'(RAM_D + 1)) && (ram_cnt <= tot));

  p_std_latency_r2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!cfg_q.fwft && $past(rd_en_i && !empty_o)) |-> valid_o);

  p_valid_drop_r5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (cfg_q.fwft && $fell(out_v_q)) |-> $past(rd_en_i));

  p_pae_at_empty_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (cfg_q.flags_on && $past(tot) == '0) |-> !pae_no);
endmodule

// File: rtl/dual_clk_prog_fifo.sv
module dual_clk_prog_fifo #(
  parameter int DW     = 18,
  parameter int AW     = 8,
  parameter int AE_DEF = 8,
  parameter int AF_DEF = 8,
  localparam int PW    = AW + 1,
  localparam int OW    = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cfg_i,
  input  logic          ofs_load_i,
  input  logic [OW-1:0] ae_ofs_i,
  input  logic [OW-1:0] af_ofs_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic          full_o,
  output logic          paf_no,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  output logic          valid_o,
  output logic          empty_o,
  output logic          pae_no
);
  logic [PW-1:0] wgray, cons_gray, rrd_gray;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] mem_rdata;
  logic          we;

  dcf_wr_side #(.AW(AW), .AF_DEF(AF_DEF)) u_wr (
    .wclk_i(wclk_i), .rst_ni(rst_ni), .cfg_i(cfg_i), .ofs_load_i(ofs_load_i),
    .af_ofs_i(af_ofs_i), .wr_en_i(wr_en_i), .cons_gray_i(cons_gray),
    .rrd_gray_i(rrd_gray), .wgray_o(wgray), .waddr_o(waddr), .we_o(we),
    .full_o(full_o), .paf_no(paf_no)
  );

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wdata_i),
    .raddr_i(raddr), .rdata_o(mem_rdata)
  );

  dcf_rd_side #(.DW(DW), .AW(AW), .AE_DEF(AE_DEF)) u_rd (
    .rclk_i(rclk_i), .rst_ni(rst_ni), .cfg_i(cfg_i), .ofs_load_i(ofs_load_i),
    .ae_ofs_i(ae_ofs_i), .rd_en_i(rd_en_i), .wgray_i(wgray),
    .mem_rdata_i(mem_rdata), .raddr_o(raddr), .cons_gray_o(cons_gray),
    .rrd_gray_o(rrd_gray), .rdata_o(rdata_o), .valid_o(valid_o),
    .empty_o(empty_o), .pae_no(pae_no)
  );
endmodule

// File: tb/sim_dual_clk_prog_fifo.sv
module sim_dual_clk_prog_fifo;
  localparam int DW = 18;
  localparam int OW = 9;

  logic wclk = 1'b0, rclk = 1'b0;
  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  logic          rst_n = 1'b0;
  logic [2:0]    cfg = 3'b100;
  logic          ofs_load = 1'b0;
  logic [OW-1:0] ae_ofs = '0, af_ofs = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          full, paf_n, valid, empty, pae_n;
  logic [DW-1:0] rdata;

  dual_clk_prog_fifo u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .cfg_i(cfg),
    .ofs_load_i(ofs_load), .ae_ofs_i(ae_ofs), .af_ofs_i(af_ofs),
    .wr_en_i(wr_en), .wdata_i(wdata), .full_o(full), .paf_no(paf_n),
    .rd_en_i(rd_en), .rdata_o(rdata), .valid_o(valid), .empty_o(empty),
    .pae_no(pae_n)
  );

  int checks = 0, fails = 0, seq = 0;
  bit done = 0, fwft = 0, flags_on = 1, pend = 0;
  int n_ofs = 8, m_ofs = 8;
  logic [DW-1:0] q[$];
  logic [DW-1:0] exp_pend;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] c, input bit ld, input int ae, input int af);
    @(negedge wclk);
    rst_n = 1'b0; cfg = c; ofs_load = ld; ae_ofs = OW'(ae); af_ofs = OW'(af);
    wr_en = 1'b0; rd_en = 1'b0;
    repeat (4) @(negedge rclk);
    chk("R9", "empty in reset", int'(empty), 1);
    chk("R9", "full in reset", int'(full), 0);
    chk("R9", "valid in reset", int'(valid), 0);
    chk("R9", "pae_n in reset", int'(pae_n), 0);
    chk("R9", "paf_n in reset", int'(paf_n), 1);
    @(negedge wclk);
    rst_n = 1'b1;
    repeat (3) @(negedge rclk);
    repeat (3) @(negedge wclk);
    ofs_load = 1'b0; ae_ofs = '0; af_ofs = '0; cfg = 3'b111;
    q.delete(); pend = 0;
    fwft = (c == 3'b101);
    flags_on = (c == 3'b100) || (c == 3'b101) || (c == 3'b110);
    n_ofs = ld ? ae : 8;
    m_ofs = ld ? af : 8;
  endtask

  task automatic wr_try(input int k, input bit gaps);
    for (int i = 0; i < k; i++) begin
      @(negedge wclk);
      if (gaps && (i % 3 == 2)) begin
        wr_en = 1'b0;
        continue;
      end
      wr_en = 1'b1;
      if (!full) begin
        wdata = DW'(seq);
        q.push_back(DW'(seq));
        seq++;
      end else begin
        wdata = '1;  // must never come out (R3)
      end
    end
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic settle_pend();
    if (pend) begin
      chk("R2", "valid after read", int'(valid), 1);
      chk("R1 R2", "read data", int'(rdata), int'(exp_pend));
      pend = 0;
    end
  endtask

  task automatic rd_try(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge rclk);
      settle_pend();
      rd_en = 1'b1;
      if (fwft) begin
        if (valid) begin
          if (q.size() == 0) chk("R1", "unexpected word", int'(rdata), -1);
          else begin
            chk("R1 R5", "head word", int'(rdata), int'(q[0]));
            void'(q.pop_front());
          end
        end
      end else if (!empty) begin
        if (q.size() == 0) chk("R4", "read while model empty", 1, 0);
        else begin
          exp_pend = q.pop_front();
          pend = 1;
        end
      end
    end
    @(negedge rclk);
    settle_pend();
    rd_en = 1'b0;
  endtask

  task automatic status(input string tag);
    int cnt, d;
    string rae, raf;
    repeat (7) @(negedge rclk);
    repeat (7) @(negedge wclk);
    @(negedge rclk);
    cnt = q.size();
    d = fwft ? 257 : 256;
    rae = !flags_on ? "R10" : (fwft ? "R7 R11" : "R6 R11");
    raf = !flags_on ? "R10" : "R8 R11";
    chk("R3", {tag, " full"}, int'(full), int'(cnt >= d));
    chk("R4", {tag, " empty"}, int'(empty), int'(cnt == 0));
    chk(rae, {tag, " pae_n"}, int'(pae_n), flags_on ? int'(!(cnt <= n_ofs + int'(fwft))) : 1);
    chk(raf, {tag, " paf_n"}, int'(paf_n), flags_on ? int'(!(cnt >= d - m_ofs)) : 1);
    if (fwft) begin
      chk("R5", {tag, " valid"}, int'(valid), int'(cnt > 0));
      if (cnt > 0) chk("R5", {tag, " fall-through data"}, int'(rdata), int'(q[0]));
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // standard mode, default offsets: n=8, m=8, D=256
    do_reset(3'b100, 1'b0, 0, 0);
    status("std empty");
    wr_try(8, 0);   status("std n");
    wr_try(1, 0);   status("std n+1");
    wr_try(238, 0); status("std D-m-1");
    wr_try(1, 0);   status("std D-m");
    wr_try(8, 0);   status("std full");
    wr_try(3, 0);   status("std writes while full");
    rd_try(260);    status("std drained");
    wr_try(2, 0);   status("std refill");
    rd_try(4);      status("std after reads past empty");

    // fall-through mode, loaded offsets: n=20, m=5, D=257
    do_reset(3'b101, 1'b1, 20, 5);
    status("ft empty");
    wr_try(1, 0);   status("ft single word");
    wr_try(20, 0);  status("ft n+1");
    wr_try(1, 0);   status("ft n+2");
    wr_try(229, 0); status("ft D-m-1");
    wr_try(1, 0);   status("ft D-m");
    wr_try(5, 0);   status("ft full");
    wr_try(2, 0);   status("ft writes while full");
    rd_try(262);    status("ft drained");

    // standard mode via second code, loaded offsets n=3, m=200
    do_reset(3'b110, 1'b1, 3, 200);
    wr_try(3, 0);   status("alt n");
    wr_try(1, 0);   status("alt n+1");
    wr_try(51, 0);  status("alt D-m-1");
    wr_try(1, 0);   status("alt D-m");
    fork
      wr_try(300, 1);
      rd_try(420);
    join
    status("alt stream");
    rd_try(80);     status("alt final");

    // undefined code: flags forced inactive
    do_reset(3'b011, 1'b0, 0, 0);
    wr_try(2, 0);   status("undef two words");
    rd_try(4);      status("undef drained");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule